// File: doc/BRIEF.md
# Four-Stage Pipelined Integer Core

This block is a compact in-order integer core. Work flows through four clocked stages: the fetch stage presents the program counter to an external instruction ROM, the operand stage decodes the word and reads the internal register file, the execute stage adds or evaluates a branch, and the store stage commits the outcome. Between each pair of neighbouring stages sits a register. That register carries the opcode, the destination register number, the operand values, the sign-extended constant and the address the instruction was fetched from.

The core executes register-register add, register-constant add, and three conditional branches: equal, not-equal, and zero-test. A branch forms its target from its own fetch address, which travels with it down the pipe. It redirects the program counter only when it reaches the store stage. At that moment the three younger instructions are turned into bubbles. The core has no forwarding and no interlock. A value written by an instruction can be read only by an instruction at least three slots later, so software pads with NOPs. Every register-file write is also shown on a registered write-back port. The surrounding logic, or a test bench, can follow the architectural state through that port.

Top module: `core4_pipe`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0 and empties every stage. While reset is held, and in the cycle after it is released, `imem_addr` is 0 and `wb_en` is 0.
- R2: When no branch is taken, the fetch address advances by 4 on every clock edge.
- R3: An instruction whose fetch address is on `imem_addr` during cycle n produces its write-back at the end of cycle n+3. The first instruction after reset therefore writes at the end of cycle 4, and the write-back port is silent before that.
- R4: The instruction word is split into fields as follows. Bits [31:28] hold the opcode, [27:24] the destination register, [23:20] the first source, [19:16] the second source, and [15:0] a signed 16-bit constant. Opcode 1 is ADD and writes r[dst] = r[src2] + r[src1], modulo 2^32.
- R5: Opcode 2 is ADDI and writes r[dst] = r[src1] + the 16-bit constant, sign-extended to 32 bits.
- R6: Register 0 always reads as zero. A write aimed at it is dropped and does not raise `wb_en`.
- R7: Opcode 3 branches when r[src1] equals r[src2]. Opcode 4 branches when they differ.
- R8: Opcode 5 branches when r[src1] is zero.
- R9: A taken branch sets the fetch address to its own fetch address plus the sign-extended constant, given in bytes. The change appears on `imem_addr` three clock edges after the branch word was latched out of the ROM.
- R10: When a branch is taken, the three instructions fetched after it write no register and take no branch.
- R11: Opcode 0 and opcodes 6 to 15 do nothing: they write no register and redirect nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | AW (8) | Byte address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid within the same cycle |
| wb_en | output | 1 | A register was written at the last edge |
| wb_reg | output | log2(NREG) (4) | Number of the register written |
| wb_data | output | XLEN (32) | Value written |

## Verification
Most internal faults show up on the write-back port within about four cycles. A wrong operand latch, a lost sign extension or a bad add gives a wrong value in `wb_data` four edges after the instruction is fetched. A branch whose squash fails lets a stray write through at once, which breaks the expected order of writes. A branch target built from the live PC, rather than the carried copy, shows up on `imem_addr` at the redirect edge, as an address 12 bytes off. The write stream is compared against an instruction-by-instruction model, and the fetch address is checked at the edges where redirects are due.

// File: rtl/core4_pkg.sv
`timescale 1ns/1ps
package core4_pkg;
  localparam int IW = 32;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDI = 4'd2,
    OP_BEQ  = 4'd3,
    OP_BNE  = 4'd4,
    OP_BZ   = 4'd5
  } opcode_t;

  // field positions of the instruction word
  localparam int OPC_LSB = 28;
  localparam int DST_LSB = 24;
  localparam int SR1_LSB = 20;
  localparam int SR2_LSB = 16;
  localparam int IMM_W   = 16;
endpackage

// File: rtl/core4_fetch.sv
`timescale 1ns/1ps
module core4_fetch #(
  parameter int AW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   redirect,
  input  logic [AW-1:0]          redirect_pc,
  input  logic [core4_pkg::IW-1:0] imem_data,
  output logic [AW-1:0]          imem_addr,
  output logic                   of_valid,
  output logic [core4_pkg::IW-1:0] of_instr,
  output logic [AW-1:0]          of_pc
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      of_valid <= 1'b0;
      of_instr <= '0;
      of_pc    <= '0;
    end else begin
      of_instr <= imem_data;
      of_pc    <= pc_q;
      if (redirect) begin
        pc_q     <= redirect_pc;
        of_valid <= 1'b0;
      end else begin
        pc_q     <= pc_q + STEP;
        of_valid <= 1'b1;
      end
    end
  end

  assign imem_addr = pc_q;
endmodule

// File: rtl/core4_regfile.sv
`timescale 1ns/1ps
module core4_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int NRD  = 2,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [RA_W-1:0]                waddr,
  input  logic [XLEN-1:0]                wdata,
  input  logic [NRD-1:0][RA_W-1:0]       raddr,
  output logic [NRD-1:0][XLEN-1:0]       rdata
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0))
      mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == '0) ? '0 : mem[raddr[g]];
  end
endmodule

// File: rtl/core4_exec.sv
`timescale 1ns/1ps
module core4_exec #(
  parameter int XLEN = 32,
  parameter int AW   = 8
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [AW-1:0]   off,
  input  logic [AW-1:0]   pc,
  output logic [XLEN-1:0] sum,
  output logic            writes,
  output logic            take,
  output logic [AW-1:0]   target
);
  import core4_pkg::*;

  always_comb begin
    sum    = opa + opb;
    target = pc + off;
    writes = 1'b0;
    take   = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDI: writes = 1'b1;
      OP_BEQ:          take   = (opa == opb);
      OP_BNE:          take   = (opa != opb);
      OP_BZ:           take   = (opa == '0);
      default: ;
    endcase
  end
endmodule

// File: rtl/core4_pipe.sv
`timescale 1ns/1ps
module core4_pipe #(
  parameter int XLEN = 32,
  parameter int AW   = 8,
  parameter int NREG = 16,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [AW-1:0]            imem_addr,
  input  logic [core4_pkg::IW-1:0] imem_data,
  output logic                     wb_en,
  output logic [RA_W-1:0]          wb_reg,
  output logic [XLEN-1:0]          wb_data
);
  import core4_pkg::*;

  // stage store -> fetch redirect
  logic            redirect;
  logic [AW-1:0]   os_target;

  // IF/OF latch
  logic            of_valid;
  logic [IW-1:0]   of_instr;
  logic [AW-1:0]   of_pc;

  core4_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .redirect(redirect), .redirect_pc(os_target),
    .imem_data(imem_data), .imem_addr(imem_addr),
    .of_valid(of_valid), .of_instr(of_instr), .of_pc(of_pc)
  );

  // operand fetch: decode and register read
  logic [3:0]            of_op;
  logic [RA_W-1:0]       of_dst;
  logic [XLEN-1:0]       of_imm;
  logic [1:0][RA_W-1:0]  rf_raddr;
  logic [1:0][XLEN-1:0]  rf_rdata;
  logic                  rf_we;

  assign of_op       = of_instr[OPC_LSB +: 4];
  assign of_dst      = of_instr[DST_LSB +: RA_W];
  assign rf_raddr[0] = of_instr[SR1_LSB +: RA_W];
  assign rf_raddr[1] = of_instr[SR2_LSB +: RA_W];
  assign of_imm      = {{(XLEN-IMM_W){of_instr[IMM_W-1]}}, of_instr[IMM_W-1:0]};

  // OF/EX latch
  logic            ex_valid;
  logic [3:0]      ex_op;
  logic [RA_W-1:0] ex_dst;
  logic [XLEN-1:0] ex_a, ex_b;
  logic [AW-1:0]   ex_off, ex_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_op    <= '0;
      ex_dst   <= '0;
      ex_a     <= '0;
      ex_b     <= '0;
      ex_off   <= '0;
      ex_pc    <= '0;
    end else begin
      ex_valid <= of_valid && !redirect;
      ex_op    <= of_op;
      ex_dst   <= of_dst;
      ex_a     <= rf_rdata[0];
      ex_b     <= (of_op == OP_ADDI) ? of_imm : rf_rdata[1];
      ex_off   <= of_imm[AW-1:0];
      ex_pc    <= of_pc;
    end
  end

  // execute
  logic [XLEN-1:0] ex_sum;
  logic            ex_writes, ex_take;
  logic [AW-1:0]   ex_target;

  core4_exec #(.XLEN(XLEN), .AW(AW)) u_exec (
    .op(ex_op), .opa(ex_a), .opb(ex_b), .off(ex_off), .pc(ex_pc),
    .sum(ex_sum), .writes(ex_writes), .take(ex_take), .target(ex_target)
  );

  // EX/OS latch
  logic            os_valid;
  logic            os_writes, os_take;
  logic [RA_W-1:0] os_dst;
  logic [XLEN-1:0] os_result;

  always_ff @(posedge clk) begin
    if (rst) begin
      os_valid  <= 1'b0;
      os_writes <= 1'b0;
      os_take   <= 1'b0;
      os_dst    <= '0;
      os_result <= '0;
      os_target <= '0;
    end else begin
      os_valid  <= ex_valid && !redirect;
      os_writes <= ex_writes;
      os_take   <= ex_take;
      os_dst    <= ex_dst;
      os_result <= ex_sum;
      os_target <= ex_target;
    end
  end

  // operand store
  assign redirect = os_valid && os_take;
  assign rf_we    = os_valid && os_writes && (os_dst != '0);

  core4_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(2)) u_rf (
    .clk(clk), .we(rf_we), .waddr(os_dst), .wdata(os_result),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en   <= 1'b0;
      wb_reg  <= '0;
      wb_data <= '0;
    end else begin
      wb_en   <= rf_we;
      wb_reg  <= os_dst;
      wb_data <= os_result;
    end
  end
endmodule

// File: rtl/core4_pipe_chk.sv
`timescale 1ns/1ps
module core4_pipe_chk #(
  parameter int AW   = 8,
  parameter int RA_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   imem_addr,
  input logic            redirect,
  input logic [AW-1:0]   os_target,
  input logic            of_valid,
  input logic            ex_valid,
  input logic            os_valid,
  input logic            wb_en,
  input logic [RA_W-1:0] wb_reg
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!wb_en && imem_addr == '0 && !of_valid && !ex_valid && !os_valid));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (imem_addr == $past(imem_addr) + AW'(4)));

  // R9
  redirect_target_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (imem_addr == $past(os_target)));

  // R10
  squash_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!of_valid && !ex_valid && !os_valid));

  // R6
  no_r0_write_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_reg != '0));
endmodule

bind core4_pipe core4_pipe_chk #(.AW(AW), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .redirect(redirect),
  .os_target(os_target), .of_valid(of_valid), .ex_valid(ex_valid),
  .os_valid(os_valid), .wb_en(wb_en), .wb_reg(wb_reg)
);

// File: tb/tb_core4_pipe.sv
`timescale 1ns/1ps
module tb_core4_pipe;
  localparam int XLEN = 32;
  localparam int AW   = 8;
  localparam int NREG = 16;
  localparam int ROMW = 64;
  localparam int PLEN = 27;

  function automatic logic [31:0] enc(input int op, input int rd, input int s1,
                                      input int s2, input logic [15:0] imm);
    return {op[3:0], rd[3:0], s1[3:0], s2[3:0], imm};
  endfunction

  // stimulus table: program words, dependents spaced by at least three slots
  localparam logic [31:0] PROG [PLEN] = '{
    enc(2, 1, 0, 0, 16'd5),       // 0  r1 = 5            R5
    enc(2, 2, 0, 0, 16'hFFFD),    // 1  r2 = -3           R5
    enc(2, 0, 0, 0, 16'd7),       // 2  r0 write dropped  R6
    enc(15, 13, 1, 2, 16'd1),     // 3  unknown opcode    R11
    enc(1, 3, 1, 2, 16'd0),       // 4  r3 = r2 + r1      R4
    enc(1, 4, 0, 0, 16'd0),       // 5  r4 = r0 + r0      R6
    32'h0,                        // 6
    enc(3, 0, 3, 1, 16'd100),     // 7  beq not taken     R7
    enc(4, 0, 3, 1, 16'd16),      // 8  bne taken -> 48   R7 R9
    enc(2, 5, 0, 0, 16'd1),       // 9  squashed          R10
    enc(2, 6, 0, 0, 16'd1),       // 10 squashed
    enc(2, 7, 0, 0, 16'd1),       // 11 squashed
    enc(2, 8, 0, 0, 16'd0),       // 12 r8 = 0
    32'h0, 32'h0,                 // 13 14
    enc(5, 0, 8, 0, 16'd8),       // 15 bz taken -> 68    R8
    enc(2, 9, 0, 0, 16'd1),       // 16 squashed
    enc(2, 9, 0, 0, 16'h7FFF),    // 17 r9 = 32767
    enc(2, 10, 0, 0, 16'h8000),   // 18 r10 = -32768      R5
    32'h0, 32'h0,                 // 19 20
    enc(1, 11, 9, 10, 16'd0),     // 21 r11 = -1          R4
    32'h0, 32'h0,                 // 22 23
    enc(5, 0, 11, 0, 16'd100),    // 24 bz not taken      R8
    enc(2, 12, 11, 0, 16'd2),     // 25 r12 = 1
    enc(3, 0, 0, 0, 16'd0)        // 26 branch to self
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   imem_addr;
  logic [31:0]     imem_data;
  logic            wb_en;
  logic [3:0]      wb_reg;
  logic [XLEN-1:0] wb_data;
  logic [31:0]     rom [ROMW];

  always #10 clk = ~clk;

  assign imem_data = rom[imem_addr[AW-1:2]];

  core4_pipe #(.XLEN(XLEN), .AW(AW), .NREG(NREG)) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model: one instruction at a time
  logic [3:0]  exp_reg [64];
  logic [31:0] exp_val [64];
  int          n_exp = 0;

  task automatic run_model();
    logic [31:0] r [16];
    logic [31:0] pc, ins, a, b, imm, tgt;
    bit take;
    for (int i = 0; i < 16; i++) r[i] = '0;
    pc = 0;
    for (int step = 0; step < 500; step++) begin
      ins  = rom[pc[7:2]];
      a    = r[ins[23:20]];
      b    = r[ins[19:16]];
      imm  = {{16{ins[15]}}, ins[15:0]};
      take = 1'b0;
      case (ins[31:28])
        4'd1, 4'd2: begin
          if (ins[27:24] != 0) begin
            r[ins[27:24]] = (ins[31:28] == 4'd1) ? a + b : a + imm;
            exp_reg[n_exp] = ins[27:24];
            exp_val[n_exp] = r[ins[27:24]];
            n_exp++;
          end
        end
        4'd3: take = (a == b);
        4'd4: take = (a != b);
        4'd5: take = (a == 0);
        default: ;
      endcase
      tgt = (pc + imm) & 32'hFF;
      if (take && tgt == pc) break;
      pc = take ? tgt : pc + 4;
    end
  endtask

  initial begin
    int widx = 0;
    for (int i = 0; i < ROMW; i++) rom[i] = (i < PLEN) ? PROG[i] : 32'h0;
    run_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, still in reset
    check(imem_addr == 0 && !wb_en, "R1", {23'd0, wb_en, imem_addr}, 32'h0);
    rst = 1'b0;
    #1;
    check(imem_addr == 0 && !wb_en, "R1", {23'd0, wb_en, imem_addr}, 32'h0);
    for (int cyc = 1; cyc <= 70; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      if (cyc == 1) check(imem_addr == 8'd4, "R2", imem_addr, 32'd4);
      if (cyc == 2) check(imem_addr == 8'd8, "R2", imem_addr, 32'd8);
      if (cyc == 3) check(!wb_en, "R3", wb_en, 32'd0);
      if (cyc == 4) check(wb_en && wb_reg == 4'd1, "R3", {wb_en, wb_reg}, 32'h11);
      if (cyc == 11) check(imem_addr == 8'd44, "R2", imem_addr, 32'd44);
      if (cyc == 12) check(imem_addr == 8'd48, "R9", imem_addr, 32'd48);
      if (cyc == 19) check(imem_addr == 8'd68, "R8", imem_addr, 32'd68);
      if (wb_en) begin
        if (widx < n_exp) begin
          check(wb_reg == exp_reg[widx] && wb_data == exp_val[widx], "R4/R5 writeback",
                {wb_reg, wb_data[27:0]}, {exp_reg[widx], exp_val[widx][27:0]});
          check(wb_data == exp_val[widx], "R4 value", wb_data, exp_val[widx]);
        end else begin
          check(1'b0, "R10 extra write", {wb_reg, wb_data[27:0]}, 32'h0);
        end
        widx++;
      end
    end
    // R10 R11: squashed and unknown instructions left no writes
    check(widx == n_exp, "R10", widx, n_exp);
    check(n_exp == 9, "R11 model", n_exp, 32'd9);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule